// File: doc/BRIEF.md
# Euler Step Engine for dy/dt = (t - y)/2

This block solves the initial-value problem dy/dt = (t - y)/2, with y(0) = 1, by the forward Euler method in signed Q8.16 fixed point (24 bits: 8 integer bits including sign, 16 fraction bits). A host presents a step size on `h` and pulses `start`. The engine then repeats Euler steps while the running time t is below 3.0. When the loop ends it raises `done` and holds the final y and the number of steps taken until the next start.

Each step reuses one signed multiplier twice. The first use forms half the step size. The second use forms the increment. A control FSM sequences the step through these states:
- `S_IDLE`: waiting after reset.
- `S_TEST`: compares t with the bound.
- `S_HALF`: first multiply; also forms t - y.
- `S_SLOPE`: second multiply.
- `S_ADVANCE`: updates t, y and the index.
- `S_DONE`: holds the result.

The transitions are:
- launch: `S_IDLE`/`S_DONE` to `S_TEST`, on start with h > 0.
- reject: `S_IDLE`/`S_DONE` to `S_DONE`, on start with h ≤ 0.
- iterate: `S_TEST` to `S_HALF`, when t < 3.0.
- finish: `S_TEST` to `S_DONE`, when t ≥ 3.0.
- `S_HALF` to `S_SLOPE`, then `S_SLOPE` to `S_ADVANCE`, then `S_ADVANCE` back to `S_TEST`: one step.

A step size that is zero or negative is refused. In that case the error flag goes up and the engine finishes at once.

Top module: `ode_euler_engine`

## Requirements
- R1: After reset, done = 0, err = 0, y = 0x010000 (1.0) and step_idx = 0.
- R2: A start accepted with h > 0 (h read as a signed Q8.16 value) sets t = 0, y = 1.0 and index = 0. Steps then repeat while signed t < 0x030000 (3.0).
- R3: Within a step, t1 = mul(h, 0.5) and t2 = t - y. Here t is the value held before that step's advance. Then dy = mul(t1, t2). mul(a, b) is floor(a·b / 2^16), kept to its low 24 bits in two's complement.
- R4: At the end of a step, t becomes t + h, y becomes y + dy and the index grows by one. All sums wrap modulo 2^24.
- R5: With h = 0x001000 (1/16) the engine reports exactly 48 steps.
- R6: A start with h ≤ 0 sets err = 1 and done = 1 on the next edge. y stays 1.0 and step_idx stays 0, with no step performed.
- R7: After it rises, done stays high with y and step_idx unchanged until the next start.
- R8: A start that arrives while the loop runs is ignored. Neither the result nor err changes.
- R9: A start with h > 0 clears err, and done is low until the loop ends.
- R10: Each step takes four clock cycles. Number the edge that samples start as 0. For a run of N steps, done is first high after edge 4N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run; sampled in idle or done |
| h | input | 24 | Step size, signed Q8.16, latched on start |
| y | output | 24 | Current/final y, signed Q8.16 |
| step_idx | output | 16 | Steps completed |
| done | output | 1 | Run finished, result valid |
| err | output | 1 | Last start had h ≤ 0 |

## Verification
The bench targets the following cases, each with the failure it would expose:
- **Step size 1/16.** A loop bound compared with ≤ instead of < would report 49 steps instead of 48.
- **Step sizes of 3.0 and larger.** These must stop after a single step. A design that computed t2 from the advanced t would produce a wrong y.
- **Zero and negative step sizes.** A design that tested h as unsigned would start iterating instead of flagging the error.
- **Start pulse during a run.** A design that accepted it would restart the loop or raise the error.

Random step sizes between 1/64 and 1.0 are compared bit for bit against a reference model. These runs expose rounding toward zero in place of floor, because the two differ once t - y goes negative. Cycle counts per run expose any state that was added or skipped.

// File: rtl/ode_pkg.sv
package ode_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_TEST,
        S_HALF,
        S_SLOPE,
        S_ADVANCE,
        S_DONE
    } ode_state_e;
endpackage

// File: rtl/ode_mul.sv
// Shared signed fixed-point multiplier: floor(a*b / 2^FRAC_W), low W bits.
module ode_mul #(
    parameter int W      = 24,
    parameter int FRAC_W = 16
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] p
);
    localparam int PW = 2 * W;
    logic signed [PW-1:0] full;

    always_comb begin
        full = PW'(a) * PW'(b);
        p    = W'(full >>> FRAC_W);
    end
endmodule

// File: rtl/ode_ctrl.sv
module ode_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic h_pos,
    input  logic t_below,
    output logic ld_init,
    output logic set_err,
    output logic do_half,
    output logic do_slope,
    output logic do_adv,
    output logic busy,
    output logic done
);
    import ode_pkg::*;

    ode_state_e state, state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE, S_DONE: begin
                if (start) state_nx = h_pos ? S_TEST : S_DONE;
            end
            S_TEST:    state_nx = t_below ? S_HALF : S_DONE;
            S_HALF:    state_nx = S_SLOPE;
            S_SLOPE:   state_nx = S_ADVANCE;
            S_ADVANCE: state_nx = S_TEST;
            default:   state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ld_init  = 1'b0;
        do_half  = 1'b0;
        do_slope = 1'b0;
        do_adv   = 1'b0;
        busy     = 1'b0;
        done     = 1'b0;
        unique case (state)
            S_IDLE:    ld_init = start;
            S_DONE:    begin ld_init = start; done = 1'b1; end
            S_TEST:    busy = 1'b1;
            S_HALF:    begin busy = 1'b1; do_half = 1'b1; end
            S_SLOPE:   begin busy = 1'b1; do_slope = 1'b1; end
            S_ADVANCE: begin busy = 1'b1; do_adv = 1'b1; end
            default:   ;
        endcase
        set_err = ld_init & ~h_pos;
    end
endmodule

// File: rtl/ode_datapath.sv
module ode_datapath #(
    parameter int W         = 24,
    parameter int FRAC_W    = 16,
    parameter int IDX_W     = 16,
    parameter int T_END_INT = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic signed [W-1:0] h_in,
    input  logic                ld_init,
    input  logic                set_err,
    input  logic                do_half,
    input  logic                do_slope,
    input  logic                do_adv,
    output logic                t_below,
    output logic signed [W-1:0] t_out,
    output logic signed [W-1:0] y_out,
    output logic [IDX_W-1:0]    idx_out,
    output logic                err_out
);
    localparam logic signed [W-1:0] ONE   = W'(1) <<< FRAC_W;
    localparam logic signed [W-1:0] HALF  = W'(1) <<< (FRAC_W - 1);
    localparam logic signed [W-1:0] T_END = W'(T_END_INT) <<< FRAC_W;

    logic signed [W-1:0] h_q, t_q, y_q, t1_q, t2_q, dy_q;
    logic signed [W-1:0] op_a, op_b, prod;
    logic [IDX_W-1:0]    idx_q;
    logic                err_q;

    // the single multiplier is shared by both products of a step
    always_comb begin
        op_a = do_half ? h_q  : t1_q;
        op_b = do_half ? HALF : t2_q;
    end

    ode_mul #(.W(W), .FRAC_W(FRAC_W)) u_mul (
        .a(op_a),
        .b(op_b),
        .p(prod)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q   <= '0;
            t_q   <= '0;
            y_q   <= ONE;
            t1_q  <= '0;
            t2_q  <= '0;
            dy_q  <= '0;
            idx_q <= '0;
            err_q <= 1'b0;
        end else begin
            if (ld_init) begin
                h_q   <= h_in;
                t_q   <= '0;
                y_q   <= ONE;
                idx_q <= '0;
                err_q <= set_err;
            end
            if (do_half) begin
                t1_q <= prod;
                t2_q <= t_q - y_q;
            end
            if (do_slope) dy_q <= prod;
            if (do_adv) begin
                t_q   <= t_q + h_q;
                y_q   <= y_q + dy_q;
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign t_below = (t_q < T_END);
    assign t_out   = t_q;
    assign y_out   = y_q;
    assign idx_out = idx_q;
    assign err_out = err_q;
endmodule

// File: rtl/ode_euler_engine.sv
module ode_euler_engine #(
    parameter int W         = 24,
    parameter int FRAC_W    = 16,
    parameter int IDX_W     = 16,
    parameter int T_END_INT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [W-1:0]     h,
    output logic [W-1:0]     y,
    output logic [IDX_W-1:0] step_idx,
    output logic             done,
    output logic             err
);
    logic ld_init, set_err, do_half, do_slope, do_adv, busy, t_below, h_pos;
    logic signed [W-1:0] t_q, y_q;

    assign h_pos = ($signed(h) > 0);

    ode_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .h_pos(h_pos),
        .t_below(t_below), .ld_init(ld_init), .set_err(set_err),
        .do_half(do_half), .do_slope(do_slope), .do_adv(do_adv),
        .busy(busy), .done(done)
    );

    ode_datapath #(.W(W), .FRAC_W(FRAC_W), .IDX_W(IDX_W), .T_END_INT(T_END_INT)) u_dp (
        .clk(clk), .rst_n(rst_n), .h_in($signed(h)), .ld_init(ld_init),
        .set_err(set_err), .do_half(do_half), .do_slope(do_slope),
        .do_adv(do_adv), .t_below(t_below), .t_out(t_q), .y_out(y_q),
        .idx_out(step_idx), .err_out(err)
    );

    assign y = y_q;
endmodule

// File: rtl/ode_euler_chk.sv
module ode_euler_chk #(
    parameter int W         = 24,
    parameter int FRAC_W    = 16,
    parameter int IDX_W     = 16,
    parameter int T_END_INT = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                done,
    input logic                err,
    input logic                busy,
    input logic [W-1:0]        y,
    input logic [IDX_W-1:0]    step_idx,
    input logic signed [W-1:0] t_val
);
    localparam logic signed [W-1:0] T_END = W'(T_END_INT) <<< FRAC_W;

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(y) && $stable(step_idx))); // R7
    AST_IDX_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (step_idx == $past(step_idx) || step_idx == $past(step_idx) + 1'b1)); // R4
    AST_ERR_NO_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && step_idx == '0)); // R6
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (!err && !done || busy == 1'b0 && !err)); // R8
    AST_FINISH_AT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && !err) |-> (t_val >= T_END)); // R2
    AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done); // R9
endmodule

bind ode_euler_engine ode_euler_chk #(
    .W(W), .FRAC_W(FRAC_W), .IDX_W(IDX_W), .T_END_INT(T_END_INT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .err(err),
    .busy(busy), .y(y), .step_idx(step_idx), .t_val(t_q)
);

// File: tb/tb_ode_euler_engine.sv
`timescale 1ns/1ps
module tb_ode_euler_engine;
    localparam int W = 24;
    localparam int IDX_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [W-1:0] h = '0;
    logic [W-1:0] y;
    logic [IDX_W-1:0] step_idx;
    logic done, err;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ode_euler_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start), .h(h),
        .y(y), .step_idx(step_idx), .done(done), .err(err)
    );

    function automatic longint wrap24(longint v);
        longint m;
        m = v & 64'hFF_FFFF;
        if (m >= 64'h80_0000) m = m - 64'h100_0000;
        return m;
    endfunction

    function automatic longint fmul(longint a, longint b);
        return wrap24((a * b) >>> 16);
    endfunction

    // reference model built from R2..R4
    function automatic void model(input longint hs, output longint ye, output longint ne);
        longint t, yy, t1, t2, dy;
        t = 0; yy = 65536; ne = 0;
        while (t < 196608 && ne < 100000) begin
            t1 = fmul(hs, 32768);
            t2 = wrap24(t - yy);
            dy = fmul(t1, t2);
            t  = wrap24(t + hs);
            yy = wrap24(yy + dy);
            ne = ne + 1;
        end
        ye = yy;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // run one case; optionally inject a start pulse mid-run (R8)
    task automatic run_case(input logic [W-1:0] hv, input bit inject, input string tag);
        longint hs, ye, ne;
        int cnt;
        hs = longint'($signed(hv));
        @(negedge clk);
        h = hv; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        cnt = 0;
        while (!done && cnt < 5000) begin
            if (inject && cnt == 6) begin h = '0; start = 1'b1; end
            if (inject && cnt == 7) start = 1'b0;
            @(posedge clk); #1;
            cnt++;
        end
        if (cnt >= 5000) begin
            check(1'b0, {"watchdog ", tag}, cnt, 0);
        end else if (hs <= 0) begin
            check(err == 1'b1, {"R6 err ", tag}, err, 1);
            check(step_idx == 0, {"R6 idx ", tag}, step_idx, 0);
            check(y == 24'h010000, {"R6 y ", tag}, y, 65536);
            check(cnt == 0, {"R6 R10 latency ", tag}, cnt, 0);
        end else begin
            model(hs, ye, ne);
            check(err == 1'b0, {"R9 err ", tag}, err, 0);
            check(longint'(step_idx) == ne, {"R2 R4 idx ", tag}, step_idx, ne);
            check(longint'($signed(y)) == ye, {"R3 R4 y ", tag}, $signed(y), ye);
            check(cnt == 4 * ne + 1, {"R10 cycles ", tag}, cnt, 4 * ne + 1);
        end
    endtask

    initial begin
        logic [W-1:0] ysave;
        logic [IDX_W-1:0] isave;
        int unused_seed;
        unused_seed = $urandom(32'd1234);
        repeat (3) @(posedge clk);
        #1;
        check(done == 1'b0, "R1 done", done, 0);
        check(err == 1'b0, "R1 err", err, 0);
        check(y == 24'h010000, "R1 y", y, 65536);
        check(step_idx == 0, "R1 idx", step_idx, 0);
        @(negedge clk); rst_n = 1'b1;

        run_case(24'h001000, 1'b0, "h=1/16");
        check(step_idx == 48, "R5 steps at h=1/16", step_idx, 48);

        // R7: result holds while no start
        ysave = y; isave = step_idx;
        repeat (6) @(posedge clk);
        #1;
        check(done && y == ysave && step_idx == isave, "R7 hold", y, ysave);

        run_case(24'h000000, 1'b0, "h=0");
        run_case(24'hFF0000, 1'b0, "h=-1.0");
        run_case(24'h010000, 1'b0, "h=1.0");      // clears err (R9)
        run_case(24'h030000, 1'b0, "h=3.0");
        run_case(24'h040000, 1'b0, "h=4.0");
        run_case(24'h7FFFFF, 1'b0, "h=max");
        run_case(24'h002000, 1'b1, "R8 inject");
        check(err == 1'b0, "R8 err after injected start", err, 0);

        for (int i = 0; i < 10; i++) begin
            logic [W-1:0] hr;
            hr = 24'h000400 + W'($urandom % 32'h0000FC01);
            run_case(hr, (i % 3) == 1, "random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule